// File: doc/BRIEF.md
# H-Bridge Drive Decoder with Latched Diagnostics

This block turns four digital control lines (direction, PWM, enable, disable) into on/off commands for the two high-side and two low-side switches of a full bridge. When the bridge is driven and PWM is high, the direction line picks which diagonal pair conducts. When PWM is low, both low-side switches are on, so the load current recirculates through transistors rather than diodes. When the bridge is not driven, all four switches are off and the bridge is at high impedance.

The block also holds a 16-bit diagnostic word. Fault flags from analog comparators arrive as single-bit inputs on a 16-bit vector, with one bit for each position of the word. Most of them are latched. The undervoltage flag and the bridge-active flag follow their sources, one clock late. Serious faults force the bridge to high impedance until they are cleared. A read strobe from the serial front end clears latched bits, under a policy bit from the configuration register. A fresh transition from not-driven to driven always clears every latched bit.

Top module: `hbridge_ctrl`

## Requirements
- R1: When `en_i` is 0 or `dis_i` is 1, all four switch commands are 0 whatever `dir_i` and `pwm_i` are.
- R2: When the bridge is driven and no blocking fault is present, PWM high with direction 1 gives `hs_o`=01 and `ls_o`=10 (output 1 high, output 2 low). PWM high with direction 0 gives `hs_o`=10 and `ls_o`=01. Bit 0 of each vector is the switch on output 1.
- R3: When the bridge is driven, no blocking fault is present and PWM is low, `ls_o`=11 and `hs_o`=00 for either direction.
- R4: Status bit 7 reads 1 during and right after reset. Otherwise it shows, one clock late, whether `en_i`=1 and `dis_i`=0. It is never latched.
- R5: Status bit 2 follows raw input bit 2 (supply undervoltage) one clock late and is not latched. While it reads 1, all switch commands are 0.
- R6: A raw fault on bit 0, 1, 3, 4, 5, 6, 8, 9, 10, 11, 14 or 15 sets the matching status bit on the next clock, and the bit stays set after the raw input drops. Raw bits 7, 12 and 13 have no effect, and status bits 12 and 13 always read 0.
- R7: While any of status bits 3 (logic-supply overvoltage), 6 (thermal shutdown) or 8..11 (overcurrent) is set, all switch commands are 0.
- R8: With the policy bit `pol_i`=0, a one-cycle `rd_i` strobe clears every latched status bit on the next clock.
- R9: With `pol_i`=1, a read clears the latched bits 0, 1, 4, 5, 14 and 15, and bits 3, 6 and 8..11 keep their value.
- R10: A rising edge of the driven condition (`en_i` && !`dis_i`), sampled on the clock, clears every latched bit on the next clock.
- R11: A bit that is cleared while its raw input is still asserted reads 0 for one clock and is set again on the clock after.
- R12: Once the blocking bits are cleared, the switch commands follow direction and PWM again, as in R2 and R3.
- R13: After reset the status word reads 0x0080.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_i | input | 1 | Direction select |
| pwm_i | input | 1 | PWM: 1 drives the load, 0 recirculates the current |
| en_i | input | 1 | Enable, active high |
| dis_i | input | 1 | Disable, active high |
| flt_i | input | 16 | Raw fault flags, one per status bit position |
| rd_i | input | 1 | One-cycle strobe: status word is being read |
| pol_i | input | 1 | Diagnostic reset policy: 1 keeps blocking faults through a read |
| hs_o | output | 2 | High-side switch commands, bit 0 on output 1 |
| ls_o | output | 2 | Low-side switch commands, bit 0 on output 1 |
| status_o | output | 16 | Diagnostic status word |

## Verification
The hardest cases to reach are the ones where two clearing causes and a setting cause fall on the same clock. Examples are a read that lands while a raw fault is still asserted, and a read under the keep policy that meets both a protected fault and an unprotected one. The stimulus holds raw faults across read strobes and across disable/enable cycles so that the clear and the re-set fall on adjacent clocks. The bench model recomputes each bit on every clock, so a wrong order between clear and set shows up at once.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int STAT_W  = 16;
  localparam int NSIDE   = 2;
  localparam int B_UV    = 2;
  localparam int B_OV    = 3;
  localparam int B_TSD   = 6;
  localparam int B_ACT   = 7;
  localparam int B_OC0   = 8;
  localparam int N_OC    = 4;
  localparam int B_NUL0  = 12;
  localparam int B_NUL1  = 13;

  // bits that hold their value after the raw flag drops
  function automatic logic [STAT_W-1:0] latch_mask_f();
    logic [STAT_W-1:0] m;
    m = '1;
    m[B_UV]   = 1'b0;
    m[B_ACT]  = 1'b0;
    m[B_NUL0] = 1'b0;
    m[B_NUL1] = 1'b0;
    return m;
  endfunction

  // faults that block the bridge and may survive a read
  function automatic logic [STAT_W-1:0] severe_mask_f();
    logic [STAT_W-1:0] m;
    m = '0;
    m[B_OV]  = 1'b1;
    m[B_TSD] = 1'b1;
    for (int i = 0; i < N_OC; i++) m[B_OC0+i] = 1'b1;
    return m;
  endfunction

  localparam logic [STAT_W-1:0] LATCH_MASK  = latch_mask_f();
  localparam logic [STAT_W-1:0] SEVERE_MASK = severe_mask_f();

  // bits a read is allowed to clear under the given policy
  function automatic logic [STAT_W-1:0] read_clear_f(input logic pol,
                                                     input logic [STAT_W-1:0] keep);
    return pol ? (LATCH_MASK & ~keep) : LATCH_MASK;
  endfunction
endpackage

// File: rtl/hb_drive_decode.sv
module hb_drive_decode
  import hb_pkg::*;
(
  input  logic             drive,
  input  logic             dir,
  input  logic             pwm,
  output logic [NSIDE-1:0] hs,
  output logic [NSIDE-1:0] ls
);
  // side 0 sources current when dir=1, side 1 when dir=0
  for (genvar k = 0; k < NSIDE; k++) begin : g_side
    localparam logic SRC_DIR = (k == 0);
    always_comb begin
      hs[k] = drive & pwm & (dir == SRC_DIR);
      ls[k] = drive & (~pwm | (dir != SRC_DIR));
    end
  end
endmodule

// File: rtl/hb_enable_track.sv
module hb_enable_track (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic dis,
  input  logic uv_raw,
  output logic active_now,
  output logic act_q,
  output logic uv_q,
  output logic en_rise
);
  assign active_now = en & ~dis;
  assign en_rise    = active_now & ~act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b1;
      uv_q  <= 1'b0;
    end else begin
      act_q <= active_now;
      uv_q  <= uv_raw;
    end
  end
endmodule

// File: rtl/hb_fault_latch.sv
module hb_fault_latch
  import hb_pkg::*;
#(
  parameter logic [STAT_W-1:0] KEEP_MASK = SEVERE_MASK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] raw,
  input  logic              rd,
  input  logic              pol,
  input  logic              en_rise,
  output logic [STAT_W-1:0] lat_q
);
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] lat_d;

  always_comb begin
    clr_vec = '0;
    if (rd)      clr_vec = clr_vec | read_clear_f(pol, KEEP_MASK);
    if (en_rise) clr_vec = clr_vec | LATCH_MASK;
    // a cleared bit skips this cycle's capture and sets again next clock
    lat_d = ~clr_vec & (lat_q | (raw & LATCH_MASK));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_d;
  end
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
  import hb_pkg::*;
#(
  parameter logic [STAT_W-1:0] KEEP_MASK = SEVERE_MASK,
  parameter logic [STAT_W-1:0] HALT_MASK = SEVERE_MASK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_i,
  input  logic              pwm_i,
  input  logic              en_i,
  input  logic              dis_i,
  input  logic [STAT_W-1:0] flt_i,
  input  logic              rd_i,
  input  logic              pol_i,
  output logic [NSIDE-1:0]  hs_o,
  output logic [NSIDE-1:0]  ls_o,
  output logic [STAT_W-1:0] status_o
);
  logic              active_now;
  logic              act_q;
  logic              uv_q;
  logic              en_rise;
  logic [STAT_W-1:0] lat_q;
  logic              halt;
  logic              drive;

  hb_enable_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en_i),
    .dis        (dis_i),
    .uv_raw     (flt_i[B_UV]),
    .active_now (active_now),
    .act_q      (act_q),
    .uv_q       (uv_q),
    .en_rise    (en_rise)
  );

  hb_fault_latch #(.KEEP_MASK(KEEP_MASK)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw     (flt_i),
    .rd      (rd_i),
    .pol     (pol_i),
    .en_rise (en_rise),
    .lat_q   (lat_q)
  );

  assign halt  = uv_q | (|(lat_q & HALT_MASK));
  assign drive = active_now & ~halt;

  hb_drive_decode u_dec (
    .drive (drive),
    .dir   (dir_i),
    .pwm   (pwm_i),
    .hs    (hs_o),
    .ls    (ls_o)
  );

  always_comb begin
    status_o        = lat_q & LATCH_MASK;
    status_o[B_UV]  = uv_q;
    status_o[B_ACT] = act_q;
  end
endmodule

// File: rtl/hbridge_ctrl_chk.sv
module hbridge_ctrl_chk
  import hb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic              dis_i,
  input logic              pwm_i,
  input logic              rd_i,
  input logic              pol_i,
  input logic [STAT_W-1:0] flt_i,
  input logic [NSIDE-1:0]  hs_o,
  input logic [NSIDE-1:0]  ls_o,
  input logic [STAT_W-1:0] status_o,
  input logic              en_rise,
  input logic              halt
);
  assert_idle_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i || dis_i) |-> (hs_o == '0 && ls_o == '0));

  assert_freewheel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !dis_i && !pwm_i && !halt) |-> (ls_o == '1 && hs_o == '0));

  assert_act_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (status_o[B_ACT] == $past(en_i && !dis_i)));

  assert_uv_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[B_UV] |-> (hs_o == '0 && ls_o == '0));

  assert_latch_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_i[0] && !rd_i && !en_rise) |=> status_o[0]);

  assert_severe_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_o & SEVERE_MASK) != '0) |-> (hs_o == '0 && ls_o == '0));

  assert_keep_on_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_i && rd_i && !en_rise && status_o[B_TSD]) |=> status_o[B_TSD]);

  assert_rise_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> ((status_o & LATCH_MASK) == '0));
endmodule

bind hbridge_ctrl hbridge_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en_i     (en_i),
  .dis_i    (dis_i),
  .pwm_i    (pwm_i),
  .rd_i     (rd_i),
  .pol_i    (pol_i),
  .flt_i    (flt_i),
  .hs_o     (hs_o),
  .ls_o     (ls_o),
  .status_o (status_o),
  .en_rise  (en_rise),
  .halt     (halt)
);

// File: tb/test_hbridge_ctrl.sv
module test_hbridge_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dir_i = 1'b0, pwm_i = 1'b0, en_i = 1'b0, dis_i = 1'b0;
  logic [15:0] flt_i = '0;
  logic        rd_i = 1'b0, pol_i = 1'b0;
  logic [1:0]  hs_o, ls_o;
  logic [15:0] status_o;

  int total = 0;
  int bad = 0;
  string tag = "R13";

  // reference state
  bit m_lat [16];
  bit m_uv;
  bit m_act;

  hbridge_ctrl i_hbridge_ctrl (
    .clk(clk), .rst_n(rst_n), .dir_i(dir_i), .pwm_i(pwm_i), .en_i(en_i),
    .dis_i(dis_i), .flt_i(flt_i), .rd_i(rd_i), .pol_i(pol_i),
    .hs_o(hs_o), .ls_o(ls_o), .status_o(status_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit holds(int b);
    return !(b == 2 || b == 7 || b == 12 || b == 13);
  endfunction

  function automatic bit blocks(int b);
    return (b == 3 || b == 6 || (b >= 8 && b <= 11));
  endfunction

  task automatic model_reset();
    foreach (m_lat[b]) m_lat[b] = 0;
    m_uv = 0;
    m_act = 1;
  endtask

  task automatic model_clock();
    bit on_now, rise, wipe;
    on_now = en_i && !dis_i;
    rise = on_now && !m_act;
    foreach (m_lat[b]) begin
      if (!holds(b)) continue;
      wipe = rise || (rd_i && !(pol_i && blocks(b)));
      if (wipe) m_lat[b] = 0;
      else if (flt_i[b]) m_lat[b] = 1;
    end
    m_uv = flt_i[2];
    m_act = on_now;
  endtask

  task automatic compare();
    logic [15:0] e_stat;
    logic [1:0]  e_hs, e_ls;
    bit stop;
    e_stat = '0;
    stop = m_uv;
    foreach (m_lat[b]) begin
      e_stat[b] = m_lat[b];
      if (m_lat[b] && blocks(b)) stop = 1;
    end
    e_stat[2] = m_uv;
    e_stat[7] = m_act;
    e_hs = 2'b00;
    e_ls = 2'b00;
    if (en_i && !dis_i && !stop) begin
      if (!pwm_i)     e_ls = 2'b11;
      else if (dir_i) begin e_hs = 2'b01; e_ls = 2'b10; end
      else            begin e_hs = 2'b10; e_ls = 2'b01; end
    end
    total++;
    if (status_o !== e_stat || hs_o !== e_hs || ls_o !== e_ls) begin
      bad++;
      $display("FAIL %s: got hs=%b ls=%b st=%h, want hs=%b ls=%b st=%h",
               tag, hs_o, ls_o, status_o, e_hs, e_ls, e_stat);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      if (rst_n) model_clock(); else model_reset();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got running, want done");
    finish_run();
  end

  initial begin
    model_reset();
    step(2);
    @(negedge clk) rst_n = 1'b1;
    tag = "R13"; step(1);                       // status 0x0080, idle

    tag = "R1";
    dir_i = 1; pwm_i = 1; en_i = 0; dis_i = 0; step(2);
    en_i = 1; dis_i = 1; step(2);
    en_i = 0; dis_i = 1; pwm_i = 0; step(2);

    tag = "R2";
    en_i = 1; dis_i = 0; pwm_i = 1; dir_i = 1; step(2);
    dir_i = 0; step(2);

    tag = "R3";
    pwm_i = 0; step(1); dir_i = 1; step(1);

    tag = "R4";
    dis_i = 1; step(2); dis_i = 0; step(2);

    tag = "R5";
    pwm_i = 1; flt_i[2] = 1; step(2); flt_i[2] = 0; step(2);

    tag = "R6";
    flt_i = 16'h3081 | 16'h0002; step(1); flt_i = '0; step(3);
    flt_i[15] = 1; step(1); flt_i = '0; step(1);

    tag = "R8";
    pol_i = 0; rd_i = 1; step(1); rd_i = 0; step(2);

    tag = "R7";
    flt_i[9] = 1; step(1); flt_i = '0; step(2);
    flt_i[3] = 1; step(1); flt_i = '0; step(2);

    tag = "R12";
    rd_i = 1; step(1); rd_i = 0; step(2);       // policy 0 read releases drive

    tag = "R9";
    pol_i = 1; flt_i[6] = 1; flt_i[4] = 1; flt_i[14] = 1; step(1);
    flt_i = '0; step(1);
    rd_i = 1; step(1); rd_i = 0; step(3);       // bit 6 kept, bridge off

    tag = "R10";
    en_i = 0; step(2); en_i = 1; step(3);
    flt_i[10] = 1; step(1); flt_i = '0;
    dis_i = 1; step(1); dis_i = 0; step(2);

    tag = "R12";
    pwm_i = 1; dir_i = 0; step(1); pwm_i = 0; step(1);

    tag = "R11";
    pol_i = 0; flt_i[1] = 1; step(2);
    rd_i = 1; step(1); rd_i = 0; step(1);      // cleared, then set again
    step(1);
    flt_i[11] = 1; step(1);
    dis_i = 1; step(1); dis_i = 0; step(1);    // edge clears while raw held
    step(1);
    flt_i = '0; rd_i = 1; step(1); rd_i = 0; step(2);

    tag = "R2";
    for (int k = 0; k < 16; k++) begin
      dir_i = k[0]; pwm_i = k[1]; en_i = !k[2] || k[3]; dis_i = k[2] && k[3];
      step(1);
    end

    finish_run();
  end
endmodule